// File: doc/BRIEF.md
# Prioritized Packet Word Transfer Controller

This controller sits between a physical-layer module and a link interface and moves variable-length packets made of 32-bit words. A requester presents a two-bit priority code and a 32-bit descriptor. The controller accepts the request when it is idle, raises a busy flag for the whole transfer, and then moves words in one of two directions.

In the send direction the controller asks the module for words with an update request and copies each word to its output. The update request is already high while the previous word is being copied out, so words move one per cycle with no stall cycles. In the receive direction each incoming word is registered and shown to the module together with an arrival flag.

An internal counter tracks the words moved and ends the transfer at the descriptor's length. An urgent request aborts a running transfer. A queued request waits until the running transfer completes.

Top module: `pxc_xfer_ctrl`

## Requirements
- R1: After reset, `busy`, `req_ack`, `upd_req`, `out_vld`, `arr_flag`, `done` and `aborted` are 0, and `word_cnt` is 0.
- R2: `req_en` code 2'b00 (and the unused code 2'b11) is no request. While idle, code 2'b01 or 2'b10 is accepted at the next edge. That edge raises `req_ack` for exactly one cycle, sets `busy`, clears `word_cnt` and loads `xfer_info` with descriptor bits 15:0.
- R3: Descriptor bits 31:16 hold the packet length in words minus one, so 0 means 1 word and 16'hFFFF means 65536 words. Descriptor bit 0 selects the direction: 0 is send, 1 is receive. Bits 15:1 do not change the transfer.
- R4: In a send transfer, `upd_req` is high from the accepting edge until the last word. Every edge with `upd_req` high captures `word_in`, which appears on `out_word` with `out_vld` high in the next cycle. Consecutive words come out in consecutive cycles.
- R5: In a receive transfer, every edge with `rx_vld` high registers `rx_word` onto `arr_word` with `arr_flag` high for one cycle. When no transfer is active, `rx_vld` has no effect.
- R6: `word_cnt` equals the number of words moved in the current transfer. It reaches 65536 for the largest packet and holds its value until the next request is accepted.
- R7: The edge that moves the last word also pulses `done` with `aborted` 0, clears `busy` and drops `upd_req`.
- R8: A 2'b10 request that arrives while `busy` is high is not accepted during the transfer. It is accepted on the edge after the `done` pulse.
- R9: A 2'b01 request seen while `busy` is high, in any cycle other than the `req_ack` cycle, aborts the transfer at the next edge. That edge moves no word, pulses `done` and `aborted` together, and clears `busy`. The new request is accepted on the following edge.
- R10: While `busy` is high, `req_ack` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 2 | Request code: 00 none, 01 urgent, 10 queued |
| req_desc | input | 32 | Descriptor: length-1 in 31:16, request data in 15:0 (bit 0 = direction) |
| word_in | input | 32 | Next send word from the module, valid while `upd_req` is high |
| rx_vld | input | 1 | Incoming receive word valid |
| rx_word | input | 32 | Incoming receive word |
| req_ack | output | 1 | One-cycle pulse when a request is accepted |
| busy | output | 1 | Transfer in progress |
| upd_req | output | 1 | Request for the next send word |
| out_vld | output | 1 | `out_word` holds a newly sent word |
| out_word | output | 32 | Sent word |
| arr_flag | output | 1 | `arr_word` holds a newly received word |
| arr_word | output | 32 | Received word |
| word_cnt | output | 17 | Words moved in the current transfer |
| xfer_info | output | 16 | Request-specific field of the accepted descriptor |
| done | output | 1 | One-cycle end-of-transfer pulse |
| aborted | output | 1 | Set with `done` when the transfer was aborted |

## Verification
The assertions check the invariants that hold on every cycle:
- an acknowledge implies busy;
- busy suppresses acknowledge in the following cycle;
- an update request is followed by either an output word or an abort;
- `done` coincides with a released busy flag;
- an abort moves no word.

Only the bench scenarios show the following:
- word order and values;
- the exact count at completion, including the 65536-word packet;
- the descriptor's direction and length decoding;
- that a queued request lands exactly one edge after `done`;
- that an abort hands over to the new request on the next edge.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } pxc_state_t;

  localparam logic [1:0] REQ_NONE   = 2'b00;
  localparam logic [1:0] REQ_URGENT = 2'b01;
  localparam logic [1:0] REQ_QUEUED = 2'b10;
endpackage

// File: rtl/pxc_req_decode.sv
module pxc_req_decode
  import pxc_pkg::*;
(
  input  logic [1:0] req_en,
  output logic       want_start,
  output logic       want_abort
);
  always_comb begin
    want_start = (req_en == REQ_URGENT) || (req_en == REQ_QUEUED);
    want_abort = (req_en == REQ_URGENT);
  end
endmodule

// File: rtl/pxc_word_ctr.sv
module pxc_word_ctr #(
  parameter int LW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        inc,
  input  logic [LW-1:0] limit,
  output logic [LW:0] cnt,
  output logic        last
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // the word about to move is the final one when cnt equals length-1
  always_comb last = (cnt == {1'b0, limit});
endmodule

// File: rtl/pxc_datapath.sv
module pxc_datapath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_cap,
  input  logic [DW-1:0] word_in,
  input  logic          rx_cap,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] out_word,
  output logic          out_vld,
  output logic [DW-1:0] arr_word,
  output logic          arr_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      arr_flag <= 1'b0;
      out_word <= '0;
      arr_word <= '0;
    end else begin
      out_vld  <= tx_cap;
      arr_flag <= rx_cap;
      if (tx_cap) out_word <= word_in;
      if (rx_cap) arr_word <= rx_word;
    end
  end
endmodule

// File: rtl/pxc_xfer_ctrl.sv
module pxc_xfer_ctrl
  import pxc_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      req_en,
  input  logic [2*LW-1:0] req_desc,
  input  logic [DW-1:0]   word_in,
  input  logic            rx_vld,
  input  logic [DW-1:0]   rx_word,
  output logic            req_ack,
  output logic            busy,
  output logic            upd_req,
  output logic            out_vld,
  output logic [DW-1:0]   out_word,
  output logic            arr_flag,
  output logic [DW-1:0]   arr_word,
  output logic [LW:0]     word_cnt,
  output logic [LW-1:0]   xfer_info,
  output logic            done,
  output logic            aborted
);
  localparam int DESC_W = 2 * LW;

  pxc_state_t    state;
  logic [LW-1:0] limit;
  logic          want_start, want_abort;
  logic          start, abort_now, tx_cap, rx_cap, moved, last, finish;

  pxc_req_decode u_dec (
    .req_en    (req_en),
    .want_start(want_start),
    .want_abort(want_abort)
  );

  always_comb begin
    start     = (state == ST_IDLE) && want_start;
    abort_now = (state != ST_IDLE) && !req_ack && want_abort;
    tx_cap    = (state == ST_SEND) && upd_req && !abort_now;
    rx_cap    = (state == ST_RECV) && rx_vld && !abort_now;
    moved     = tx_cap || rx_cap;
    finish    = moved && last;
  end

  pxc_word_ctr #(.LW(LW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (moved),
    .limit(limit),
    .cnt  (word_cnt),
    .last (last)
  );

  pxc_datapath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .tx_cap  (tx_cap),
    .word_in (word_in),
    .rx_cap  (rx_cap),
    .rx_word (rx_word),
    .out_word(out_word),
    .out_vld (out_vld),
    .arr_word(arr_word),
    .arr_flag(arr_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      limit     <= '0;
      xfer_info <= '0;
      busy      <= 1'b0;
      upd_req   <= 1'b0;
      req_ack   <= 1'b0;
      done      <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      done    <= 1'b0;
      aborted <= 1'b0;
      if (start) begin
        state     <= req_desc[0] ? ST_RECV : ST_SEND;
        limit     <= req_desc[DESC_W-1:LW];
        xfer_info <= req_desc[LW-1:0];
        busy      <= 1'b1;
        req_ack   <= 1'b1;
        upd_req   <= !req_desc[0];
      end else if (abort_now) begin
        state   <= ST_IDLE;
        busy    <= 1'b0;
        upd_req <= 1'b0;
        done    <= 1'b1;
        aborted <= 1'b1;
      end else if (finish) begin
        state   <= ST_IDLE;
        busy    <= 1'b0;
        upd_req <= 1'b0;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pxc_xfer_chk.sv
module pxc_xfer_chk (
  input logic clk,
  input logic rst,
  input logic req_ack,
  input logic busy,
  input logic upd_req,
  input logic out_vld,
  input logic done,
  input logic aborted
);
  p_ack_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> busy);

  p_busy_blocks_ack_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !req_ack);

  p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> (out_vld || aborted));

  p_upd_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
    upd_req |-> busy);

  p_done_releases_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !upd_req));

  p_abort_no_word_r9: assert property (@(posedge clk) disable iff (rst)
    aborted |-> (done && !out_vld));
endmodule

bind pxc_xfer_ctrl pxc_xfer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_ack(req_ack),
  .busy   (busy),
  .upd_req(upd_req),
  .out_vld(out_vld),
  .done   (done),
  .aborted(aborted)
);

// File: tb/sim_pxc_xfer_ctrl.sv
module sim_pxc_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_en = 2'b00;
  logic [31:0] req_desc = '0;
  logic [31:0] word_in = '0;
  logic        rx_vld = 1'b0;
  logic [31:0] rx_word = '0;
  logic        req_ack, busy, upd_req, out_vld, arr_flag, done, aborted;
  logic [31:0] out_word, arr_word;
  logic [16:0] word_cnt;
  logic [15:0] xfer_info;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pxc_xfer_ctrl u0 (
    .clk(clk), .rst(rst), .req_en(req_en), .req_desc(req_desc),
    .word_in(word_in), .rx_vld(rx_vld), .rx_word(rx_word),
    .req_ack(req_ack), .busy(busy), .upd_req(upd_req),
    .out_vld(out_vld), .out_word(out_word), .arr_flag(arr_flag),
    .arr_word(arr_word), .word_cnt(word_cnt), .xfer_info(xfer_info),
    .done(done), .aborted(aborted)
  );

  task automatic expect_eq(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // present a request and wait for its acknowledge; returns at the ack negedge
  task automatic issue(input logic [1:0] pr, input logic [31:0] d);
    bit seen = 0;
    @(negedge clk);
    req_en = pr;
    req_desc = d;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (req_ack) seen = 1;
    end
    expect_eq("R2", "request acknowledged", seen, 1);
    expect_eq("R2", "busy after accept", busy, 1);
    expect_eq("R2", "xfer_info loaded", xfer_info, d[15:0]);
    req_en = 2'b00;
  endtask

  task automatic run_send(input int n, input logic [31:0] base);
    word_in = base;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expect_eq("R4", "out_vld each cycle", out_vld, 1);
      expect_eq("R4", "out_word order", out_word, base + i);
      expect_eq("R6", "word count", word_cnt, i + 1);
      expect_eq("R10", "no ack while busy", req_ack, 0);
      expect_eq("R7", "done on last word", done, (i == n - 1));
      word_in = base + i + 1;
    end
    expect_eq("R7", "busy released", busy, 0);
    expect_eq("R7", "not aborted", aborted, 0);
    expect_eq("R7", "upd_req dropped", upd_req, 0);
  endtask

  task automatic run_recv(input int n, input logic [31:0] base, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        rx_vld = 1'b0;
        @(negedge clk);
        expect_eq("R5", "no arrival in gap", arr_flag, 0);
        expect_eq("R5", "busy held in gap", busy, 1);
      end
      rx_vld = 1'b1;
      rx_word = base ^ i;
      @(negedge clk);
      rx_vld = 1'b0;
      expect_eq("R5", "arrival flag", arr_flag, 1);
      expect_eq("R5", "arrival word", arr_word, base ^ i);
      expect_eq("R6", "recv word count", word_cnt, i + 1);
      expect_eq("R7", "recv done on last", done, (i == n - 1));
    end
    expect_eq("R7", "recv busy released", busy, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1", "busy", busy, 0);
    expect_eq("R1", "req_ack", req_ack, 0);
    expect_eq("R1", "upd_req", upd_req, 0);
    expect_eq("R1", "out_vld", out_vld, 0);
    expect_eq("R1", "arr_flag", arr_flag, 0);
    expect_eq("R1", "done/aborted", {done, aborted}, 0);
    expect_eq("R1", "word_cnt", word_cnt, 0);
  endtask

  task automatic t_idle_ignore;
    req_en = 2'b11;
    rx_vld = 1'b1;
    rx_word = 32'hDEAD_0001;
    repeat (3) @(negedge clk);
    expect_eq("R5", "idle rx ignored", arr_flag, 0);
    expect_eq("R5", "idle count unchanged", word_cnt, 0);
    expect_eq("R2", "code 11 not accepted", busy, 0);
    rx_vld = 1'b0;
    req_en = 2'b00;
    repeat (2) @(negedge clk);
    expect_eq("R2", "code 00 not accepted", busy, 0);
  endtask

  task automatic t_send_basic;
    // bits 15:1 full of junk, bit 0 = 0 -> send, length 5
    issue(2'b10, {16'd4, 16'hABCE});
    expect_eq("R3", "send direction raises upd_req", upd_req, 1);
    expect_eq("R6", "count cleared", word_cnt, 0);
    run_send(5, 32'h1000_0000);
    repeat (2) @(negedge clk);
    expect_eq("R6", "count held after done", word_cnt, 5);
  endtask

  task automatic t_single;
    issue(2'b01, {16'd0, 16'h0000});
    run_send(1, 32'h2222_0000);
  endtask

  task automatic t_recv;
    issue(2'b10, {16'd2, 16'h0001});
    expect_eq("R3", "recv direction no upd_req", upd_req, 0);
    run_recv(3, 32'h3300_00F0, 1'b1);
  endtask

  task automatic t_queued;
    issue(2'b10, {16'd3, 16'h0000});
    req_en = 2'b10;
    req_desc = {16'd1, 16'h0010};
    run_send(4, 32'h4400_0000);
    @(negedge clk);
    expect_eq("R8", "queued accepted after done", req_ack, 1);
    expect_eq("R8", "busy for queued", busy, 1);
    req_en = 2'b00;
    run_send(2, 32'h4500_0000);
  endtask

  task automatic t_abort;
    issue(2'b10, {16'd9, 16'h0000});
    word_in = 32'h5500_0000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_eq("R4", "pre-abort word", out_word, 32'h5500_0000 + i);
      word_in = 32'h5500_0000 + i + 1;
    end
    req_en = 2'b01;
    req_desc = {16'd1, 16'h0001};
    @(negedge clk);
    expect_eq("R9", "abort done", done, 1);
    expect_eq("R9", "abort flag", aborted, 1);
    expect_eq("R9", "abort busy cleared", busy, 0);
    expect_eq("R9", "no word on abort", out_vld, 0);
    expect_eq("R9", "count at abort", word_cnt, 3);
    @(negedge clk);
    expect_eq("R9", "new request loaded", req_ack, 1);
    expect_eq("R9", "busy for new request", busy, 1);
    req_en = 2'b00;
    run_recv(2, 32'h5A5A_0000, 1'b0);
  endtask

  task automatic t_long;
    int bad = 0;
    issue(2'b01, {16'hFFFF, 16'h0000});
    word_in = 32'h0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (!out_vld || out_word != i || done != (i == 65535)) bad++;
      word_in = i + 1;
    end
    expect_eq("R6", "long packet mismatches", bad, 0);
    expect_eq("R6", "count 65536", word_cnt, 17'h10000);
    expect_eq("R7", "long busy released", busy, 0);
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_ignore();
    t_send_basic();
    t_single();
    t_recv();
    t_queued();
    t_abort();
    t_long();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule